// File: doc/BRIEF.md
# Memory Access Cycle Calculator

This block prices a single memory access in wait cycles for either of two processor profiles, a fast core and a slow core. Each request carries a core select, an access kind (instruction fetch or data), a size, a direction and an address. The block keeps four last-address registers, one for each pairing of core and kind. It uses them to tell sequential accesses from non-sequential ones, and it returns the cost one clock after the request strobe.

The fast core has two local-memory shortcuts. Instruction fetches from low addresses cost one cycle. Data accesses that fall into a programmable 16 KiB data window also cost one cycle. Main memory on the fast core is priced with a fixed approximation: it is cheap when sequential and costs the halfword-bus rate when not. Every other access is priced from a 16-entry region table indexed by address bits [27:24]. A core-dependent surcharge is added when the access is not sequential.

A combiner turns the results into a per-instruction total. It keeps a running sum of the memory costs of one instruction, which is restarted by a clear input. It merges this sum with an ALU cycle count and a fetch cycle count. The fast core overlaps ALU and memory work, so it takes the maximum of the two. The slow core adds them. Both cores overlap execute with fetch.

Top module: `mem_wait_calc`

## Requirements
- R1: `cost_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, and it is low after reset. `cost_cycles` holds the price of that request.
- R2: The address is first aligned down to the access size (`req_size` 0 = 8 bit / 1 byte, 1 = 16 bit / 2 bytes, 2 or 3 = 32 bit / 4 bytes). The access is sequential when the aligned address equals its stream's stored address plus the size in bytes, with 32-bit wrap. The stream is selected by `{req_core, req_kind}`. Each stored address resets to all ones, and it is replaced by the aligned address only on a strobed request. Right after reset, a byte access to address 0 is therefore sequential.
- R3: The cost constants depend on the core (`req_core` 0 = fast, 1 = slow).
  - The word-bus cost W is 2 on the fast core and 1 on the slow core.
  - The halfword-bus cost H is 2·W for 32-bit accesses and W otherwise.
  - The slow-device cost S is 8·H.
- R4: On the fast core, an instruction fetch (`req_kind` 0) whose address is below 0x0200_0000 costs 1.
- R5: On the fast core, a data access (`req_kind` 1) costs 1 when its aligned address with bits [13:0] cleared equals `tcm_base` with bits [13:0] cleared. The low 14 bits of `tcm_base` have no effect.
- R6: On the fast core, any other access with address bits [27:24] = 2 costs 1 when sequential and H when not.
- R7: All remaining accesses take a base cost from region bits [27:24]:
  - regions 0–1 cost 1;
  - regions 2, 5 and 6 cost H;
  - regions 3, 4, 7 and 11–15 cost W;
  - regions 8–10 cost S.
- R8: A non-sequential access priced from the region table costs 6 extra cycles on the fast core and 1 extra cycle on the slow core.
- R9: `req_write` has no effect on the cost.
- R10: The memory sum adds each valid `cost_cycles` value. On `acc_clear` the sum is reloaded with the cost that is valid in that cycle, or with 0 if none is valid.
- R11: `exec_total` is max(`alu_cycles`, sum) when `comb_core` = 0 and `alu_cycles` + sum when `comb_core` = 1.
- R12: `instr_total` is max(`exec_total`, `fetch_cycles`) for both cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_core | input | 1 | 0 fast core, 1 slow core |
| req_kind | input | 1 | 0 instruction fetch, 1 data |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_write | input | 1 | Direction, 1 write |
| req_addr | input | AW (32) | Access address |
| tcm_base | input | AW (32) | Data window base, bits [13:0] ignored |
| cost_valid | output | 1 | Cost is valid |
| cost_cycles | output | CW (8) | Wait cycles of the request |
| acc_clear | input | 1 | Start a new instruction's memory sum |
| comb_core | input | 1 | Combiner profile, 0 fast, 1 slow |
| alu_cycles | input | TW (12) | ALU cycles of the instruction |
| fetch_cycles | input | TW (12) | Fetch cycles of the instruction |
| exec_total | output | TW+1 (13) | Execute-stage total |
| instr_total | output | TW+1 (13) | Per-instruction total |

## Verification
The hardest state to reach from the ports is a sequential hit in a stream whose neighbours have just been active. Random addresses almost never land on the previous address plus the size. The stimulus therefore often builds its next address from the bench's own copy of the chosen stream's last address. It interleaves the other three streams and idle cycles in between, which shows that the streams and the strobe gating stay independent. Directed cases also cover the wrap from the all-ones reset value, the data-window match with junk in the ignored base bits, and a fast-core fetch in the data window, which must fall through to the table.

// File: rtl/mem_wait_calc.sv
module mem_wait_calc #(
  parameter int AW         = 32,
  parameter int CW         = 8,
  parameter int TW         = 12,
  parameter int TCM_SHIFT  = 14,
  parameter int REGION_LSB = 24,
  parameter logic [31:0] CODE_LIMIT = 32'h0200_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_core,
  input  logic          req_kind,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] tcm_base,
  output logic          cost_valid,
  output logic [CW-1:0] cost_cycles,
  input  logic          acc_clear,
  input  logic          comb_core,
  input  logic [TW-1:0] alu_cycles,
  input  logic [TW-1:0] fetch_cycles,
  output logic [TW:0]   exec_total,
  output logic [TW:0]   instr_total
);
  localparam int SW = TW + 1;
  localparam int NSTREAM = 4;

  logic [AW-1:0] last_q [NSTREAM];
  logic [1:0]    sid;
  logic [AW-1:0] nbytes, aligned, win_mask;
  logic          is_fast, seq, wide32;
  logic [3:0]    region;
  logic [CW-1:0] c32, c16, cslw, tab, penalty, cost_d;
  logic [TW-1:0] acc_q;
  logic [SW-1:0] mem_ext, alu_ext, fetch_ext;
  logic          unused_bits;

  assign unused_bits = req_write;

  assign sid      = {req_core, req_kind};
  assign is_fast  = ~req_core;
  assign wide32   = req_size[1];
  assign nbytes   = (req_size == 2'd0) ? AW'(1) : (req_size == 2'd1) ? AW'(2) : AW'(4);
  assign aligned  = req_addr & ~(nbytes - AW'(1));
  assign seq      = (aligned == last_q[sid] + nbytes);
  assign win_mask = ~((AW'(1) << TCM_SHIFT) - AW'(1));
  assign region   = req_addr[REGION_LSB +: 4];

  assign c32     = is_fast ? CW'(2) : CW'(1);
  assign c16     = wide32 ? (c32 << 1) : c32;
  assign cslw    = c16 << 3;
  assign penalty = is_fast ? CW'(6) : CW'(1);

  always_comb begin
    case (region)
      4'h0, 4'h1:             tab = CW'(1);
      4'h2, 4'h5, 4'h6:       tab = c16;
      4'h8, 4'h9, 4'hA:       tab = cslw;
      default:                tab = c32;
    endcase
  end

  always_comb begin
    if (is_fast && !req_kind && (req_addr < AW'(CODE_LIMIT)))
      cost_d = CW'(1);
    else if (is_fast && req_kind && ((aligned & win_mask) == (tcm_base & win_mask)))
      cost_d = CW'(1);
    else if (is_fast && region == 4'h2)
      cost_d = seq ? CW'(1) : c16;
    else
      cost_d = tab + (seq ? CW'(0) : penalty);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTREAM; i++) last_q[i] <= '1;
      cost_valid  <= 1'b0;
      cost_cycles <= '0;
    end else begin
      cost_valid <= req_valid;
      if (req_valid) begin
        last_q[sid] <= aligned;
        cost_cycles <= cost_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      acc_q <= '0;
    else if (acc_clear)
      acc_q <= cost_valid ? TW'(cost_cycles) : '0;
    else if (cost_valid)
      acc_q <= acc_q + TW'(cost_cycles);
  end

  assign mem_ext   = SW'(acc_q);
  assign alu_ext   = SW'(alu_cycles);
  assign fetch_ext = SW'(fetch_cycles);

  assign exec_total  = comb_core ? (alu_ext + mem_ext)
                                 : ((alu_ext > mem_ext) ? alu_ext : mem_ext);
  assign instr_total = (exec_total > fetch_ext) ? exec_total : fetch_ext;

  // R1
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> cost_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !cost_valid);
  // R3
  cost_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cost_valid |-> (cost_cycles >= CW'(1) && cost_cycles <= CW'(38)));
  // R10
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clear && !cost_valid) |=> (acc_q == '0));
  // R12
  instr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_total >= exec_total) && (instr_total >= fetch_ext));
  // R11
  exec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_total >= alu_ext) && (exec_total >= mem_ext));
endmodule

// File: tb/mem_wait_calc_tb_top.sv
module mem_wait_calc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_core = 1'b0, req_kind = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, tcm_base = 32'h0B00_3FFF;
  logic        cost_valid;
  logic [7:0]  cost_cycles;
  logic        acc_clear = 1'b0, comb_core = 1'b0;
  logic [11:0] alu_cycles = '0, fetch_cycles = '0;
  logic [12:0] exec_total, instr_total;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_wait_calc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
    .req_kind(req_kind), .req_size(req_size), .req_write(req_write),
    .req_addr(req_addr), .tcm_base(tcm_base), .cost_valid(cost_valid),
    .cost_cycles(cost_cycles), .acc_clear(acc_clear), .comb_core(comb_core),
    .alu_cycles(alu_cycles), .fetch_cycles(fetch_cycles),
    .exec_total(exec_total), .instr_total(instr_total));

  int checks = 0, errors = 0;
  logic [31:0] m_last [4];
  logic        m_cv = 1'b0;
  int          m_cost = 0, m_acc = 0;
  string       m_tag = "R1";
  bit          done = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nb(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic ref_cost(output int c, output string tag);
    int b, w, h, s, pen, tb;
    logic [31:0] al;
    logic [3:0] rg;
    bit sq, fast;
    b = nb(req_size);
    al = req_addr & ~(32'(b) - 32'd1);
    sq = (al == m_last[{req_core, req_kind}] + 32'(b));
    m_last[{req_core, req_kind}] = al;
    fast = !req_core;
    w = fast ? 2 : 1;
    h = (b == 4) ? 2 * w : w;
    s = 8 * h;
    pen = fast ? 6 : 1;
    rg = req_addr[27:24];
    if (rg <= 1) tb = 1;
    else if (rg == 2 || rg == 5 || rg == 6) tb = h;
    else if (rg >= 8 && rg <= 10) tb = s;
    else tb = w;
    if (fast && !req_kind && req_addr < 32'h0200_0000) begin c = 1; tag = "R4"; end
    else if (fast && req_kind && (al[31:14] == tcm_base[31:14])) begin c = 1; tag = "R5"; end
    else if (fast && rg == 4'h2) begin c = sq ? 1 : h; tag = "R6"; end
    else begin c = tb + (sq ? 0 : pen); tag = sq ? "R7" : "R8"; end
  endtask

  task automatic tick();
    int ex, ins, c;
    string t;
    @(posedge clk);
    if (acc_clear) m_acc = m_cv ? m_cost : 0;
    else if (m_cv) m_acc = m_acc + m_cost;
    m_cv = req_valid;
    if (req_valid) begin ref_cost(c, t); m_cost = c; m_tag = t; end
    @(negedge clk);
    chk(cost_valid == m_cv, "R1 valid", int'(cost_valid), int'(m_cv));
    if (m_cv) chk(int'(cost_cycles) == m_cost, m_tag, int'(cost_cycles), m_cost);
    ex = comb_core ? int'(alu_cycles) + m_acc
                   : ((int'(alu_cycles) > m_acc) ? int'(alu_cycles) : m_acc);
    ins = (ex > int'(fetch_cycles)) ? ex : int'(fetch_cycles);
    chk(int'(exec_total) == ex, "R11 exec (R10 sum)", int'(exec_total), ex);
    chk(int'(instr_total) == ins, "R12 instr", int'(instr_total), ins);
  endtask

  task automatic req(bit core, bit kind, logic [1:0] sz, bit wr, logic [31:0] a);
    req_valid = 1'b1; req_core = core; req_kind = kind;
    req_size = sz; req_write = wr; req_addr = a;
    tick();
    req_valid = 1'b0;
  endtask

  initial begin
    int r;
    for (int i = 0; i < 4; i++) m_last[i] = '1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cost_valid == 1'b0, "R1 reset valid", int'(cost_valid), 0);
    chk(exec_total == 13'd0, "R10 reset sum", int'(exec_total), 0);

    req(1, 1, 2'd0, 0, 32'h0000_0000);            // R2 wrap from all ones: sequential, 1
    req(0, 0, 2'd2, 0, 32'h0200_0000);            // R6 non-seq fast main: 4
    req(0, 1, 2'd1, 0, 32'h0300_0000);            // other stream
    tick();                                       // idle cycle
    req_addr = 32'h0900_0000; tick();             // R2 unstrobed address ignored
    req(0, 0, 2'd2, 0, 32'h0200_0004);            // R2 R6 sequential: 1
    req(1, 1, 2'd2, 0, 32'h0800_0000);            // R8 slow: 16+1
    req(1, 1, 2'd2, 0, 32'h0800_0004);            // R7 seq: 16
    req(0, 1, 2'd1, 0, 32'h0800_0101);            // R8 fast half: 16+6, aligned
    req(1, 1, 2'd2, 0, 32'h0500_0020);            // R9 read: 3
    req(1, 1, 2'd2, 1, 32'h0500_0020);            // R9 write: 3
    req(0, 1, 2'd2, 0, 32'h0B00_0010);            // R5 window hit: 1
    req(0, 0, 2'd2, 0, 32'h0B00_0010);            // R5 fetch not in window: 2+6
    req(0, 0, 2'd0, 0, 32'h01FF_FFFF);            // R4 low fetch: 1
    req(0, 1, 2'd2, 0, 32'h0100_0000);            // R8 fast data low region: 1+6
    req(1, 0, 2'd2, 0, 32'h0100_0000);            // R3 slow table 1+1

    for (int n = 0; n < 4000; n++) begin
      logic [1:0] sz;
      bit co, ki;
      co = 1'($urandom); ki = 1'($urandom); sz = 2'($urandom);
      req_valid = ($urandom % 5) != 0;
      req_core = co; req_kind = ki; req_size = sz; req_write = 1'($urandom);
      r = $urandom % 8;
      if (r < 3) req_addr = m_last[{co, ki}] + 32'(nb(sz));
      else if (r == 3) req_addr = 32'h0B00_0000 | ($urandom & 32'h3FFF);
      else req_addr = $urandom & 32'h0FFF_FFFF;
      acc_clear = ($urandom % 4) == 0;
      comb_core = 1'($urandom);
      alu_cycles = 12'($urandom % 48);
      fetch_cycles = 12'($urandom % 64);
      tick();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule